// File: doc/BRIEF.md
# Single-Cycle Byte Execution Datapath

This block is the data side of a small processor in which every instruction finishes in one clock. It takes a 16-bit instruction word and the current carry flag. It holds six 8-bit working registers: two address-high registers, two index registers, a scratch register and an accumulator. In the same cycle it computes a byte offset, forms a 16-bit data-memory address, picks either the ALU result or the data RAM byte as its source, and then updates one register or raises one strobe.

Every instruction computes the same offset. An 8-bit constant is OR-ed with an optional term (index-low register plus the carry flag), and the optional index-high register is added to the result. The offset then serves two purposes: it is the low address byte, and it is the mask input of the ALU, which XORs the accumulator with the masked value. The instruction fetch unit owns the carry flag and the program counter. This block returns a flag update, a page-load strobe, a plain output port and five forwarded peripheral strobes.

Top module: `byte_exec_core`

## Requirements
- R1: The instruction fields are, from bit 15 down: destination [15:13], source [12] (0 = ALU, 1 = RAM), high select [11] (0 = `a_hi`, 1 = `b_hi`), index-low use [10], index-high use [9], accumulator use [8], constant [7:0]. `ram_addr` equals the selected high register concatenated with the offset.
- R2: offset = (constant OR (index-low use ? (a_lo + flag_i) mod 256 : 0)) + (index-high use ? b_lo : 0), truncated to 8 bits. The carry out of the 8-bit index-low increment is discarded.
- R3: For destination codes 0 (`a_hi`), 1 (`a_lo`), 2 (`b_lo`) and 3 (`acc`) in ALU mode, the register receives (accumulator use ? acc : 0) XOR (a_hi AND offset) at the clock edge that ends the instruction.
- R4: For destination codes 0 to 3 in RAM mode, the register receives `ram_rdata`.
- R5: Destination 7 raises `ram_we`. `ram_wdata` is `scr` XOR `acc` in ALU mode and 0 in RAM mode.
- R6: Destination 4 in ALU mode writes a_hi AND offset into `scr` and raises `flag_we`, with `flag_d` equal to the carry out of the final offset addition. In RAM mode it loads `scr` from `ram_rdata` and leaves the flag alone.
- R7: Destination 5 raises `pc_load`. `pc_data` is the value that R3 or R4 would produce. No register changes.
- R8: Destination 6 in ALU mode raises `out_valid`, with `out_data` = `scr` XOR `acc`.
- R9: Destination 6 in RAM mode dispatches on acc[2:0]. Code 0 loads `scr` from the bus. Code 1 loads `b_hi`. Code 2 raises `flag_we` with `flag_d` = (bus == 0). Codes 3 to 7 raise `ext_strb` bit (code − 3), with `ext_data` = bus. The bit order is page load, page load with counter clear, serial address, serial data, video.
- R10: While `rst_n` is low, all registers clear to 0 at each clock edge and no strobe is raised.
- R11: At most one of `ram_we`, `pc_load`, `out_valid` and the `ext_strb` bits is active in any cycle.
- R12: Registers that the destination does not name keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 16 | Instruction word |
| flag_i | input | 1 | Current carry flag |
| flag_we | output | 1 | Flag update strobe |
| flag_d | output | 1 | New flag value |
| ram_addr | output | 16 | Data memory address |
| ram_rdata | input | 8 | Data memory read byte (combinational) |
| ram_we | output | 1 | Data memory write strobe |
| ram_wdata | output | 8 | Data memory write byte |
| pc_load | output | 1 | Program page load strobe |
| pc_data | output | 8 | Program page value |
| out_valid | output | 1 | Output port strobe |
| out_data | output | 8 | Output port byte |
| ext_strb | output | 5 | One-hot peripheral strobes |
| ext_data | output | 8 | Peripheral data byte |

## Verification
The embedded properties check several rules on every cycle: that strobes are mutually exclusive, that nothing fires during reset, that registers clear under reset and hold when not written, that a RAM-mode store writes zero, that the flag is updated only by its two destinations, and that the discarded index-low carry never leaks into the offset. Whether the values themselves are right can only be shown by the bench. This covers the offset arithmetic, the XOR-mask result, the carry into the flag, the zero test and the selector dispatch. The bench runs a long pseudo-random instruction sweep against an arithmetic reference model. It reads every register back through the address and output ports, and it adds directed cases for the index-low wrap, the carry out and the zero test.

// File: rtl/bxc_pkg.sv
// Package: shared field layout, destination codes and register indices
// for the byte execution datapath. Assumes an 8-bit control field above
// a data-width constant field.
package bxc_pkg;

    typedef enum logic [2:0] {
        D_AHI = 3'd0,
        D_ALO = 3'd1,
        D_BLO = 3'd2,
        D_ACC = 3'd3,
        D_SCF = 3'd4,
        D_PCL = 3'd5,
        D_OUT = 3'd6,
        D_RAM = 3'd7
    } dst_e;

    typedef struct packed {
        dst_e dst;
        logic src_ram;
        logic hi_b;
        logic use_alo;
        logic use_blo;
        logic use_acc;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // register file indices
    localparam int R_AHI = 0;
    localparam int R_ALO = 1;
    localparam int R_BHI = 2;
    localparam int R_BLO = 3;
    localparam int R_SCR = 4;
    localparam int R_ACC = 5;
    localparam int NREG  = 6;

    // forwarded peripheral strobes (selector codes 3..7)
    localparam int EXT_BASE = 3;
    localparam int NEXT     = 8 - EXT_BASE;

endpackage

// File: rtl/bxc_offset.sv
// Module: offset unit. Builds the per-instruction byte offset from the
// constant, the optional index-low plus flag term and the optional
// index-high addend; reports the carry of the final addition.
// Assumes purely combinational use within one cycle.
module bxc_offset #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] konst,
    input  logic [DW-1:0] alo,
    input  logic [DW-1:0] blo,
    input  logic          use_alo,
    input  logic          use_blo,
    input  logic          flag,
    output logic [DW-1:0] off,
    output logic          carry
);
    logic [DW-1:0] alo_inc;
    logic [DW-1:0] pre;
    logic [DW-1:0] addend;
    logic [DW:0]   sum;

    // Offset arithmetic: wrapped increment, OR with constant, add index-high.
    always_comb begin
        alo_inc = alo + {{(DW-1){1'b0}}, flag};
        pre     = konst | (use_alo ? alo_inc : '0);
        addend  = use_blo ? blo : '0;
        sum     = {1'b0, pre} + {1'b0, addend};
        off     = sum[DW-1:0];
        carry   = sum[DW];
    end

    // Check that a full-scale index-low increment contributes nothing.
    always_comb begin
        if (use_alo && (alo == '1) && flag)
            AST_ALO_WRAP: assert (pre == konst); // R2
    end
endmodule

// File: rtl/bxc_regfile.sv
// Module: six-entry working register file with one shared write port.
// Assumes at most one enable is high per cycle; synchronous active-low reset.
module bxc_regfile #(
    parameter int DW   = 8,
    parameter int NREG = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NREG-1:0]          we,
    input  logic [DW-1:0]            wd,
    output logic [NREG-1:0][DW-1:0]  q
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // Register i: clear on reset, load on its enable.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= '0;
            else if (we[i])
                q[i] <= wd;
        end

        AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !we[i] |=> $stable(q[i])); // R12
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (q == '0)); // R10
endmodule

// File: rtl/bxc_route.sv
// Module: destination router. Picks the result source and turns the
// destination code into register enables, flag update and strobes.
// Assumes operands are settled within the cycle; everything is gated by reset.
module bxc_route
    import bxc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                rst_n,
    input  ctl_t                ctl,
    input  logic [DW-1:0]       s_val,
    input  logic [DW-1:0]       acc,
    input  logic [DW-1:0]       scr,
    input  logic [DW-1:0]       rdata,
    input  logic                carry,
    output logic [NREG-1:0]     wr_en,
    output logic [DW-1:0]       wr_data,
    output logic                flag_we,
    output logic                flag_d,
    output logic                ram_we,
    output logic [DW-1:0]       ram_wdata,
    output logic                pc_load,
    output logic [DW-1:0]       pc_data,
    output logic                out_valid,
    output logic [DW-1:0]       out_data,
    output logic [NEXT-1:0]     ext_strb
);
    logic [DW-1:0] alu_res;
    logic [DW-1:0] reg_res;
    logic [2:0]    sel;

    // Source selection: masked XOR from the ALU or the RAM byte.
    always_comb begin
        alu_res  = (ctl.use_acc ? acc : '0) ^ s_val;
        reg_res  = ctl.src_ram ? rdata : alu_res;
        pc_data  = reg_res;
        out_data = scr ^ acc;
        sel      = acc[2:0];
    end

    // Destination decode into enables and strobes.
    always_comb begin
        wr_en     = '0;
        wr_data   = reg_res;
        flag_we   = 1'b0;
        flag_d    = carry;
        ram_we    = 1'b0;
        ram_wdata = scr ^ acc;
        pc_load   = 1'b0;
        out_valid = 1'b0;
        ext_strb  = '0;
        if (rst_n) begin
            unique case (ctl.dst)
                D_AHI: wr_en[R_AHI] = 1'b1;
                D_ALO: wr_en[R_ALO] = 1'b1;
                D_BLO: wr_en[R_BLO] = 1'b1;
                D_ACC: wr_en[R_ACC] = 1'b1;
                D_SCF: begin
                    wr_en[R_SCR] = 1'b1;
                    if (ctl.src_ram) begin
                        wr_data = rdata;
                    end else begin
                        wr_data = s_val;
                        flag_we = 1'b1;
                    end
                end
                D_PCL: pc_load = 1'b1;
                D_OUT: begin
                    if (!ctl.src_ram) begin
                        out_valid = 1'b1;
                    end else begin
                        wr_data = rdata;
                        case (sel)
                            3'd0: wr_en[R_SCR] = 1'b1;
                            3'd1: wr_en[R_BHI] = 1'b1;
                            3'd2: begin
                                flag_we = 1'b1;
                                flag_d  = (rdata == '0);
                            end
                            default: ext_strb[sel - 3'(EXT_BASE)] = 1'b1;
                        endcase
                    end
                end
                D_RAM: begin
                    ram_we = 1'b1;
                    if (ctl.src_ram)
                        ram_wdata = '0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/byte_exec_core.sv
// Module: top of the single-cycle byte execution datapath. Splits the
// instruction, computes offset and address, and routes the result.
// Assumes combinational RAM reads; writes land on the edge ending the cycle.
module byte_exec_core
    import bxc_pkg::*;
#(
    parameter int DW = 8,
    localparam int IW = CTL_W + DW,
    localparam int AW = 2 * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IW-1:0]     instr,
    input  logic              flag_i,
    output logic              flag_we,
    output logic              flag_d,
    output logic [AW-1:0]     ram_addr,
    input  logic [DW-1:0]     ram_rdata,
    output logic              ram_we,
    output logic [DW-1:0]     ram_wdata,
    output logic              pc_load,
    output logic [DW-1:0]     pc_data,
    output logic              out_valid,
    output logic [DW-1:0]     out_data,
    output logic [NEXT-1:0]   ext_strb,
    output logic [DW-1:0]     ext_data
);
    ctl_t                     ctl;
    logic [DW-1:0]            konst;
    logic [NREG-1:0][DW-1:0]  rq;
    logic [NREG-1:0]          wr_en;
    logic [DW-1:0]            wr_data;
    logic [DW-1:0]            off;
    logic                     carry;
    logic [DW-1:0]            s_val;

    // Field split and address formation.
    always_comb begin
        ctl      = ctl_t'(instr[IW-1 -: CTL_W]);
        konst    = instr[DW-1:0];
        s_val    = rq[R_AHI] & off;
        ram_addr = {(ctl.hi_b ? rq[R_BHI] : rq[R_AHI]), off};
        ext_data = ram_rdata;
    end

    bxc_offset #(.DW(DW)) u_off (
        .konst   (konst),
        .alo     (rq[R_ALO]),
        .blo     (rq[R_BLO]),
        .use_alo (ctl.use_alo),
        .use_blo (ctl.use_blo),
        .flag    (flag_i),
        .off     (off),
        .carry   (carry)
    );

    bxc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .wd    (wr_data),
        .q     (rq)
    );

    bxc_route #(.DW(DW)) u_route (
        .rst_n     (rst_n),
        .ctl       (ctl),
        .s_val     (s_val),
        .acc       (rq[R_ACC]),
        .scr       (rq[R_SCR]),
        .rdata     (ram_rdata),
        .carry     (carry),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .flag_we   (flag_we),
        .flag_d    (flag_d),
        .ram_we    (ram_we),
        .ram_wdata (ram_wdata),
        .pc_load   (pc_load),
        .pc_data   (pc_data),
        .out_valid (out_valid),
        .out_data  (out_data),
        .ext_strb  (ext_strb)
    );

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_we, pc_load, out_valid, ext_strb})); // R11

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> !(ram_we || pc_load || out_valid || flag_we || (ext_strb != '0))); // R10

    AST_RAM_ZERO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && instr[IW-CTL_W+4]) |-> (ram_wdata == '0)); // R5

    AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> (instr[IW-1 -: 3] == 3'd4 || instr[IW-1 -: 3] == 3'd6)); // R6

    AST_PC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> $stable(rq)); // R7
endmodule

// File: tb/byte_exec_core_test.sv
module byte_exec_core_test;
    localparam int CLK_T = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = '0;
    logic        flag_i = 1'b0;
    logic        flag_we, flag_d, ram_we, pc_load, out_valid;
    logic [15:0] ram_addr;
    logic [7:0]  ram_rdata, ram_wdata, pc_data, out_data, ext_data;
    logic [4:0]  ext_strb;

    int checks = 0;
    int fails  = 0;

    // reference model state
    logic [7:0] mAH, mAL, mBH, mBL, mSX, mDX;

    always #(CLK_T/2) clk = ~clk;

    function automatic logic [7:0] mem_f(input logic [15:0] a);
        return a[15:8] ^ {a[6:0], a[7]} ^ 8'h3C;
    endfunction

    assign ram_rdata = mem_f(ram_addr);

    byte_exec_core uut (
        .clk(clk), .rst_n(rst_n), .instr(instr), .flag_i(flag_i),
        .flag_we(flag_we), .flag_d(flag_d), .ram_addr(ram_addr),
        .ram_rdata(ram_rdata), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .pc_load(pc_load), .pc_data(pc_data), .out_valid(out_valid),
        .out_data(out_data), .ext_strb(ext_strb), .ext_data(ext_data)
    );

    function automatic logic [15:0] mk(input int d, input bit s, input bit hb,
                                       input bit ua, input bit ub, input bit ud,
                                       input logic [7:0] k);
        return {d[2:0], s, hb, ua, ub, ud, k};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one instruction: drive, compare all outputs with the model, advance the model
    task automatic run_step(input logic [15:0] ins, input bit f);
        logic [2:0] d; bit sr, hb, ua, ub, ud;
        logic [7:0] k, t, off, hi, rd, s, res;
        logic [8:0] sum9; bit cy;
        bit e_fwe, e_fd, e_we, e_pcl, e_ov; logic [7:0] e_wd, e_od; logic [4:0] e_es;
        @(negedge clk);
        instr = ins; flag_i = f;
        #1;
        {d, sr, hb, ua, ub, ud, k} = ins;
        t    = ua ? 8'(mAL + {7'd0, f}) : 8'd0;
        sum9 = {1'b0, k | t} + {1'b0, (ub ? mBL : 8'd0)};
        off  = sum9[7:0]; cy = sum9[8];
        hi   = hb ? mBH : mAH;
        rd   = mem_f({hi, off});
        s    = mAH & off;
        res  = sr ? rd : ((ud ? mDX : 8'd0) ^ s);
        e_fwe = 0; e_fd = 0; e_we = 0; e_pcl = 0; e_ov = 0; e_es = '0;
        e_wd = mSX ^ mDX; e_od = mSX ^ mDX;
        chk(ram_addr == {hi, off}, "R1/R2 addr", ram_addr, {hi, off});
        case (d)
            3'd4: if (!sr) begin e_fwe = 1; e_fd = cy; end
            3'd5: e_pcl = 1;
            3'd6: if (!sr) e_ov = 1;
                  else if (mDX[2:0] == 3'd2) begin e_fwe = 1; e_fd = (rd == 0); end
                  else if (mDX[2:0] >= 3'd3) e_es = 5'(1 << (mDX[2:0] - 3'd3));
            3'd7: begin e_we = 1; if (sr) e_wd = 8'd0; end
            default: ;
        endcase
        chk(ram_we == e_we, "R5 we", ram_we, e_we);
        if (e_we) chk(ram_wdata == e_wd, "R5 wdata", ram_wdata, e_wd);
        chk(flag_we == e_fwe, "R6/R9 flag_we", flag_we, e_fwe);
        if (e_fwe) chk(flag_d == e_fd, "R6/R9 flag_d", flag_d, e_fd);
        chk(pc_load == e_pcl, "R7 pc_load", pc_load, e_pcl);
        if (e_pcl) chk(pc_data == res, "R7 pc_data", pc_data, res);
        chk(out_valid == e_ov, "R8 out_valid", out_valid, e_ov);
        if (e_ov) chk(out_data == e_od, "R8 out_data", out_data, e_od);
        chk(ext_strb == e_es, "R9 ext_strb", ext_strb, e_es);
        if (e_es != 0) chk(ext_data == rd, "R9 ext_data", ext_data, rd);
        chk($countones({ram_we, pc_load, out_valid, ext_strb}) <= 1, "R11 strobes",
            {ram_we, pc_load, out_valid, ext_strb}, 0);
        case (d)
            3'd0: mAH = res;
            3'd1: mAL = res;
            3'd2: mBL = res;
            3'd3: mDX = res;
            3'd4: mSX = sr ? rd : s;
            3'd6: if (sr && mDX[2:0] == 3'd0) mSX = rd;
                  else if (sr && mDX[2:0] == 3'd1) mBH = rd;
            default: ;
        endcase
    endtask

    // read every register back through the ports with side-effect-free instructions
    task automatic probe(input string tag);
        logic [7:0] pAH, pAL, pBH, pBL, pSX, pDX, sxdx;
        @(negedge clk); instr = mk(6, 0, 0, 0, 0, 0, 8'h00); flag_i = 0; #1;
        pAH = ram_addr[15:8]; sxdx = out_data;
        @(negedge clk); instr = mk(6, 0, 1, 1, 0, 0, 8'h00); #1;
        pBH = ram_addr[15:8]; pAL = ram_addr[7:0];
        @(negedge clk); instr = mk(6, 0, 0, 0, 1, 0, 8'h00); #1;
        pBL = ram_addr[7:0];
        @(negedge clk); instr = mk(5, 0, 0, 0, 0, 1, 8'h00); #1;
        pDX = pc_data; pSX = sxdx ^ pDX;
        chk(pAH == mAH, {tag, " a_hi"}, pAH, mAH);
        chk(pAL == mAL, {tag, " a_lo"}, pAL, mAL);
        chk(pBH == mBH, {tag, " b_hi"}, pBH, mBH);
        chk(pBL == mBL, {tag, " b_lo"}, pBL, mBL);
        chk(pSX == mSX, {tag, " scr"},  pSX, mSX);
        chk(pDX == mDX, {tag, " acc"},  pDX, mDX);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; instr = mk(7, 0, 0, 0, 0, 0, 8'h00);
        #1;
        chk(!ram_we && !pc_load && !out_valid && !flag_we && ext_strb == 0,
            "R10 quiet", ram_we, 0);
        repeat (2) @(negedge clk);
        rst_n = 1;
        mAH = 0; mAL = 0; mBH = 0; mBL = 0; mSX = 0; mDX = 0;
    endtask

    initial begin
        #(CLK_T * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] lf = 32'h1ACE_B00C;
        do_reset();
        probe("R10 reset");
        // R4: a_hi <= mem[0000] = 3C
        run_step(mk(0, 1, 0, 0, 0, 0, 8'h00), 0);
        // R4: acc <= mem[3C01] = 02
        run_step(mk(3, 1, 0, 0, 0, 0, 8'h01), 0);
        probe("R4 load");
        // R9: selector 2, mem[3C00] = 0 so flag_d = 1
        run_step(mk(6, 1, 0, 0, 0, 0, 8'h00), 0);
        // R3: a_lo <= acc ^ (3C & F0) = 32
        run_step(mk(1, 0, 0, 0, 0, 1, 8'hF0), 0);
        probe("R3 alu");
        chk(mAL == 8'h32, "R3 value", mAL, 8'h32);
        // R2: a_lo = FF, with flag the increment wraps to 0 -> offset = constant
        run_step(mk(1, 1, 0, 0, 0, 0, 8'hFF), 0);
        @(negedge clk); instr = mk(6, 0, 0, 1, 0, 0, 8'h12); flag_i = 1; #1;
        chk(ram_addr[7:0] == 8'h12, "R2 wrap", ram_addr[7:0], 8'h12);
        // R6: b_lo <= mem[3C80] = 01, then FF + 01 carries out
        run_step(mk(2, 1, 0, 0, 0, 0, 8'h80), 0);
        @(negedge clk); instr = mk(4, 0, 0, 0, 1, 0, 8'hFF); flag_i = 0; #1;
        chk(flag_we && flag_d, "R6 carry", {flag_we, flag_d}, 2'b11);
        run_step(mk(4, 0, 0, 0, 1, 0, 8'hFF), 0);
        probe("R6 scr");
        // pseudo-random sweep of all destinations, modes and selectors
        for (int n = 0; n < 3000; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            run_step(lf[15:0], lf[20]);
            if (n % 16 == 15) probe("R12 sweep");
        end
        // R10: reset in mid-run clears everything
        do_reset();
        probe("R10 rerun");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule